// File: doc/BRIEF.md
# Dual-Lane SIMD Saturating Multiplier

This block multiplies two 32-bit register operands in one of several ways and returns one 32-bit word for a general register. Each operand is viewed as two 16-bit halfword lanes or as four bytes. A 3-bit operation code selects the mode. The modes are:

- a single fractional Q15 × Q15 product from the upper or the lower halfword pair, widened and saturated to Q31;
- a two-lane unsigned byte × halfword integer product, taking its bytes from the upper or the lower half of the first operand;
- a two-lane fractional Q15 product with rounding, packing two Q15 results into one word.

Every lane that has to clip its result raises a sticky saturation flag. The flag stays set until reset.

The block takes one operation per cycle when `op_valid` is high and registers the result. The result appears one clock later with `res_valid`. While no operation is presented, the registered result holds its value. Accumulators and instruction decode sit outside the block.

Top module: `simd_sat_mul`

## Requirements
- R1: After a synchronous active-low reset, `res_word` is 0, `res_valid` is 0 and `sat_sticky` is 0.
- R2: An operation accepted with `op_valid` high at a clock edge shows its result on `res_word`, with `res_valid` high, after that same edge; `res_valid` always equals `op_valid` as sampled at the previous edge.
- R3: At an edge where `op_valid` is low, `res_word` and `sat_sticky` keep their values whatever `op_code`, `opnd_a` and `opnd_b` carry.
- R4: Code 3'd0 takes `opnd_a[31:16]` and `opnd_b[31:16]`; code 3'd1 takes `opnd_a[15:0]` and `opnd_b[15:0]`. Both halves are signed Q15, and the result is their signed product doubled, as a 32-bit Q31 value.
- R5: In codes 3'd0 and 3'd1, when both selected halfwords are 16'h8000 the result is 32'h7FFFFFFF and `sat_sticky` becomes 1.
- R6: Code 3'd2 multiplies, as unsigned integers, `opnd_a[31:24]` by `opnd_b[31:16]` into `res_word[31:16]`, and `opnd_a[23:16]` by `opnd_b[15:0]` into `res_word[15:0]`.
- R7: Code 3'd3 does the same with `opnd_a[15:8]` for the upper lane and `opnd_a[7:0]` for the lower lane.
- R8: In codes 3'd2 and 3'd3, a lane whose product exceeds 16'hFFFF yields 16'hFFFF and sets `sat_sticky`. The other lane is unaffected.
- R9: Code 3'd4 forms, per lane (upper halves into bits 31:16, lower halves into bits 15:0), twice the signed product plus 32'h00008000, and keeps bits 31:16 of that sum as a Q15 result.
- R10: In code 3'd4, a lane whose two halfwords are both 16'h8000 yields 16'h7FFF and sets `sat_sticky`.
- R11: Codes 3'd5, 3'd6 and 3'd7 give a result of 0 and do not set `sat_sticky`.
- R12: `sat_sticky` rises after an accepted operation in which any lane saturated, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation presented this cycle |
| op_code | input | 3 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| res_valid | output | 1 | Result registered from an accepted operation |
| res_word | output | 32 | Registered result word |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Every operation code is swept over a 16 × 16 grid of halfword values. The grid includes zero, ±1, both extremes, 16'h8001 and mixed-sign patterns. It shows whether signs, doubling and rounding carry right, and it puts the lone saturating Q15 pair on one lane while the other lane stays normal. The operands are built so that the upper and lower byte pairs differ. The byte modes therefore tell the "upper" and "lower" byte selection apart, and they tell a clipped lane from an unclipped neighbour. A reset before each code lets the unused codes show that the flag stays low. An idle cycle after every operation, with scrambled inputs, shows that the result holds.

// File: rtl/simd_mul_pkg.sv
// Package: operation codes and shared widths of the dual-lane multiplier.
// Assumes the op code is 3 bits wide; codes not listed here give zero.
package simd_mul_pkg;
    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_Q15W_UP  = 3'd0;  // Q15 x Q15 -> Q31, upper halves
    localparam logic [OP_W-1:0] OP_Q15W_LOW = 3'd1;  // Q15 x Q15 -> Q31, lower halves
    localparam logic [OP_W-1:0] OP_BXH_UP   = 3'd2;  // byte x half, upper byte pair
    localparam logic [OP_W-1:0] OP_BXH_LOW  = 3'd3;  // byte x half, lower byte pair
    localparam logic [OP_W-1:0] OP_Q15_RND2 = 3'd4;  // two-lane rounded Q15
endpackage

// File: rtl/q15_lane_mul.sv
// Module: one signed fractional lane.
// Multiplies two signed Q-format halfwords. It gives a doubled full-width
// product that clips to the positive maximum, and a rounded half-width result.
// Assumes two's complement; the only overflowing pair is min x min.
module q15_lane_mul #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0]   x_half,
    input  logic [LANE_W-1:0]   y_half,
    output logic [2*LANE_W-1:0] wide_q,
    output logic [LANE_W-1:0]   rnd_q,
    output logic                clip
);
    localparam int PROD_W = 2 * LANE_W;
    localparam logic [LANE_W-1:0] MIN_H = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] MAX_H = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [PROD_W-1:0] MAX_W = {1'b0, {(PROD_W-1){1'b1}}};
    localparam logic [PROD_W-1:0] RND_K = PROD_W'(1) << (LANE_W - 1);

    logic signed [PROD_W-1:0] prod_s;
    logic        [PROD_W-1:0] dbl;
    logic        [PROD_W-1:0] rsum;

    // Signed product, doubled to align the fraction point, then rounded.
    always_comb begin
        prod_s = $signed(x_half) * $signed(y_half);
        dbl    = PROD_W'(prod_s) << 1;
        rsum   = dbl + RND_K;
        clip   = (x_half == MIN_H) && (y_half == MIN_H);
        wide_q = clip ? MAX_W : dbl;
        rnd_q  = clip ? MAX_H : rsum[PROD_W-1:LANE_W];
    end
endmodule

// File: rtl/ubh_lane_mul.sv
// Module: one unsigned byte x halfword integer lane.
// Clips the product to the all-ones halfword when it does not fit.
// Assumes both inputs are unsigned integers.
module ubh_lane_mul #(
    parameter int BYTE_W = 8,
    parameter int LANE_W = 16
) (
    input  logic [BYTE_W-1:0] b_in,
    input  logic [LANE_W-1:0] h_in,
    output logic [LANE_W-1:0] prod_q,
    output logic              clip
);
    localparam int PW = BYTE_W + LANE_W;

    logic [PW-1:0] prod;

    // Full-width unsigned product; any bit above the lane means overflow.
    always_comb begin
        prod   = PW'(b_in) * PW'(h_in);
        clip   = |prod[PW-1:LANE_W];
        prod_q = clip ? {LANE_W{1'b1}} : prod[LANE_W-1:0];
    end
endmodule

// File: rtl/simd_sat_mul.sv
// Module: top of the dual-lane SIMD saturating multiplier.
// Splits the operands into two lanes, runs a signed fractional unit and an
// unsigned byte x half unit per lane, picks the result by op code and registers
// it together with a sticky saturation flag. Latency is one cycle.
// Assumes one operation per cycle and a synchronous active-low reset.
module simd_sat_mul
    import simd_mul_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [OP_W-1:0]       op_code,
    input  logic [2*LANE_W-1:0]   opnd_a,
    input  logic [2*LANE_W-1:0]   opnd_b,
    output logic                  res_valid,
    output logic [2*LANE_W-1:0]   res_word,
    output logic                  sat_sticky
);
    localparam int NLANE  = 2;
    localparam int DATA_W = NLANE * LANE_W;
    localparam int BYTE_W = LANE_W / 2;
    localparam logic [LANE_W-1:0] MIN_H = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MAX_W = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] wide_q [NLANE];
    logic [LANE_W-1:0] rnd_q  [NLANE];
    logic [LANE_W-1:0] bxh_q  [NLANE];
    logic [NLANE-1:0]  q_clip;
    logic [NLANE-1:0]  b_clip;
    logic [DATA_W-1:0] nxt_word;
    logic              nxt_sat;

    // One fractional unit and one byte x half unit for each lane.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [BYTE_W-1:0] byte_sel;

        // Byte source: the upper byte pair for code 2, the lower pair otherwise.
        always_comb begin
            byte_sel = (op_code == OP_BXH_UP)
                     ? opnd_a[DATA_W/2 + g*BYTE_W +: BYTE_W]
                     : opnd_a[g*BYTE_W +: BYTE_W];
        end

        q15_lane_mul #(.LANE_W(LANE_W)) u_q15 (
            .x_half (opnd_a[g*LANE_W +: LANE_W]),
            .y_half (opnd_b[g*LANE_W +: LANE_W]),
            .wide_q (wide_q[g]),
            .rnd_q  (rnd_q[g]),
            .clip   (q_clip[g])
        );

        ubh_lane_mul #(.BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_bxh (
            .b_in   (byte_sel),
            .h_in   (opnd_b[g*LANE_W +: LANE_W]),
            .prod_q (bxh_q[g]),
            .clip   (b_clip[g])
        );
    end

    // Result and saturation selection by operation code.
    always_comb begin
        nxt_word = '0;
        nxt_sat  = 1'b0;
        case (op_code)
            OP_Q15W_UP: begin
                nxt_word = wide_q[1];
                nxt_sat  = q_clip[1];
            end
            OP_Q15W_LOW: begin
                nxt_word = wide_q[0];
                nxt_sat  = q_clip[0];
            end
            OP_BXH_UP, OP_BXH_LOW: begin
                nxt_word = {bxh_q[1], bxh_q[0]};
                nxt_sat  = |b_clip;
            end
            OP_Q15_RND2: begin
                nxt_word = {rnd_q[1], rnd_q[0]};
                nxt_sat  = |q_clip;
            end
            default: begin
                nxt_word = '0;
                nxt_sat  = 1'b0;
            end
        endcase
    end

    // Output register: capture on accepted ops, accumulate the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_word   <= '0;
            sat_sticky <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_word   <= nxt_word;
                sat_sticky <= sat_sticky | nxt_sat;
            end
        end
    end

    // R2: valid output follows the accepted input by one cycle.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(op_valid)));

    // R3: idle cycles leave the result untouched.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid)) |-> ($stable(res_word) && $stable(sat_sticky)));

    // R5: upper-half min x min clips to the Q31 maximum and flags it.
    p_min_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && ($past(op_code) == OP_Q15W_UP)
         && ($past(opnd_a[DATA_W-1:LANE_W]) == MIN_H)
         && ($past(opnd_b[DATA_W-1:LANE_W]) == MIN_H))
        |-> ((res_word == MAX_W) && sat_sticky));

    // R11: unused codes give zero and leave the flag alone.
    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && ($past(op_code) > OP_Q15_RND2))
        |-> ((res_word == '0) && (sat_sticky == $past(sat_sticky))));

    // R12: the flag never drops without reset.
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sat_sticky |=> sat_sticky);
endmodule

// File: tb/simd_sat_mul_tb_top.sv
// Bench: sweeps every op code over a 16 x 16 grid of operand patterns and
// compares against an arithmetic reference computed here.
module simd_sat_mul_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        res_valid;
    logic [31:0] res_word;
    logic        sat_sticky;

    int n_chk = 0;
    int n_fail = 0;
    logic exp_flag;

    always #4 clk = ~clk;  // 125 MHz

    simd_sat_mul dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
        .res_word(res_word), .sat_sticky(sat_sticky)
    );

    function automatic logic [15:0] pat(int i);
        case (i)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;  3: return 16'h8000;
            4: return 16'h7FFF;  5: return 16'h8001;  6: return 16'h4000;  7: return 16'hC000;
            8: return 16'h1234;  9: return 16'hABCD; 10: return 16'h0100; 11: return 16'h00FF;
            12: return 16'hFF00; 13: return 16'h2000; 14: return 16'hE000; default: return 16'h0002;
        endcase
    endfunction

    function automatic logic [32:0] q15w(logic [15:0] x, logic [15:0] y);
        longint p;
        if (x == 16'h8000 && y == 16'h8000) return {1'b1, 32'h7FFFFFFF};
        p = longint'($signed(x)) * longint'($signed(y)) * 2;
        return {1'b0, p[31:0]};
    endfunction

    function automatic logic [16:0] bxh(logic [7:0] x, logic [15:0] y);
        longint p;
        p = longint'(x) * longint'(y);
        if (p > 65535) return {1'b1, 16'hFFFF};
        return {1'b0, p[15:0]};
    endfunction

    function automatic logic [16:0] rnd(logic [15:0] x, logic [15:0] y);
        longint p;
        if (x == 16'h8000 && y == 16'h8000) return {1'b1, 16'h7FFF};
        p = longint'($signed(x)) * longint'($signed(y)) * 2 + 32768;
        return {1'b0, p[31:16]};
    endfunction

    // Returns {saturated, result}.
    function automatic logic [32:0] ref_model(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        logic [16:0] hi, lo;
        case (op)
            3'd0: return q15w(a[31:16], b[31:16]);
            3'd1: return q15w(a[15:0], b[15:0]);
            3'd2: begin hi = bxh(a[31:24], b[31:16]); lo = bxh(a[23:16], b[15:0]);
                        return {hi[16] | lo[16], hi[15:0], lo[15:0]}; end
            3'd3: begin hi = bxh(a[15:8], b[31:16]); lo = bxh(a[7:0], b[15:0]);
                        return {hi[16] | lo[16], hi[15:0], lo[15:0]}; end
            3'd4: begin hi = rnd(a[31:16], b[31:16]); lo = rnd(a[15:0], b[15:0]);
                        return {hi[16] | lo[16], hi[15:0], lo[15:0]}; end
            default: return 33'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R4/R5";
            3'd2: return "R6/R8";
            3'd3: return "R7/R8";
            3'd4: return "R9/R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_flag = 1'b0;
        check("R1 res_word", res_word, 32'h0);
        check("R1 res_valid", {31'b0, res_valid}, 32'h0);
        check("R1 sat_sticky", {31'b0, sat_sticky}, 32'h0);
    endtask

    task automatic run_op(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        logic [32:0] e;
        logic [31:0] held;
        e = ref_model(op, a, b);
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        // Idle cycle with scrambled inputs that must be ignored.
        op_valid = 1'b0; op_code = 3'd0; opnd_a = 32'h80008000; opnd_b = 32'h80008000;
        exp_flag = exp_flag | e[32];
        check(tag_of(op), res_word, e[31:0]);
        check("R2 res_valid", {31'b0, res_valid}, 32'h1);
        check({tag_of(op), " R12 flag"}, {31'b0, sat_sticky}, {31'b0, exp_flag});
        held = res_word;
        @(negedge clk);
        check("R3 hold", res_word, held);
        check("R3 flag hold", {31'b0, sat_sticky}, {31'b0, exp_flag});
        check("R2 res_valid low", {31'b0, res_valid}, 32'h0);
    endtask

    initial begin
        exp_flag = 1'b0;
        repeat (2) @(negedge clk);
        for (int op = 0; op < 8; op++) begin
            do_reset();
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    run_op(3'(op), {pat(i), pat(15 - i)}, {pat(j), pat(j ^ 5)});
                end
            end
        end
        // R12: flag survives later clean operations, until reset.
        do_reset();
        run_op(3'd4, 32'h80000001, 32'h80000001);
        run_op(3'd1, 32'h00010002, 32'h00030004);
        check("R12 sticky after clean op", {31'b0, sat_sticky}, 32'h1);
        do_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule